// File: doc/BRIEF.md
# IR Interval Capture and Replay

This block learns an infrared remote-control code and sends it again later. While learning, it watches the stream from an infrared receiver that has already removed the carrier. The stream rests high and goes low while the remote emits light. The block measures each high and low stretch in microseconds and writes the lengths into one of three on-chip code slots. It does not decode ones and zeros. It only keeps the raw timing. Every code opens with a low lead-in pulse, which is measured but not kept.

When replaying, the block first sends a fixed lead-in burst. It then walks through the stored lengths of the selected slot. Each length is loaded into a counter that steps down once per microsecond. The LED drive carries a 50% duty carrier during low stretches and stays dark during high stretches. The microsecond strobe and the carrier both come from the system clock through enable pulses. The block makes no extra clock.

Top module: `irc_capture_replay`

## Requirements
- R1: After reset, `led_o`, `done_o` and `ack_o` are low.
- R2: A start in learn mode (`mode_i` = 0) measures the receiver stream on a 1 µs strobe. After the low lead-in, each interval is stored as its length in µs. Entry 0 is the first high interval, and the stored entries then alternate high and low: an even index is high, an odd index is low.
- R3: An interval of exactly `MAX_US` µs (default 4000) is stored. An interval longer than `MAX_US` ends learning: a zero is written into the next entry, and `ack_o` pulses for one cycle.
- R4: Learning stops once 32 entries are stored. `ack_o` pulses right after the 32nd interval ends, no zero is written, and later activity on the stream is ignored.
- R5: Slot `k` occupies addresses `k*32` to `k*32+31`. Learning into one slot leaves every other slot unchanged.
- R6: A start with a code index of 3 is ignored. No `ack_o` or `done_o` follows, and `led_o` stays low.
- R7: A start in replay mode (`mode_i` = 1) first sends a carrier burst lasting `START_US` µs. Each stored entry then lasts its value in µs: an even index is dark and an odd index carries the carrier.
- R8: Replay ends on a stored zero entry or after 32 entries. `done_o` then pulses for one cycle and `led_o` stays low afterwards.
- R9: The carrier has a 50% duty cycle. Its half-period is CLK_HZ/(2·CARRIER_HZ) clocks, rounded to the nearest whole clock, and every burst begins with a high half-period.
- R10: A start that arrives while learning or replay is in progress is ignored.
- R11: The length of the learned lead-in pulse has no effect. The replay lead-in is always `START_US` µs long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (5 MHz by default) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_rx_i | input | 1 | Receiver stream with carrier removed; idles high, low while the remote emits light |
| mode_i | input | 1 | Selects the operation: 0 learns a code, 1 replays one |
| code_sel_i | input | 2 | Slot index: 0, 1 or 2 |
| start_i | input | 1 | Single-cycle request that begins the selected operation |
| ack_o | output | 1 | Pulses for one cycle when learning finishes |
| done_o | output | 1 | Pulses for one cycle when replay finishes |
| led_o | output | 1 | LED drive, carrier-gated |

## Verification
The assertions check the following on every cycle:
- every written length is nonzero and within the limit, and every write falls inside a valid slot;
- the entry count never passes 32;
- the replay down-counter never sits at zero while running;
- the strobes are one cycle wide, and every burst opens on a high carrier phase;
- the LED is dark whenever replay reports done.

Only the bench scenarios can show that learned timing replays exactly. They learn random and boundary codes, replay them, and measure burst and gap lengths at the LED pin. The same scenarios show that the limit and fill-up endings fall on the right entry, that slots stay independent, and that ignored starts leave no trace.

// File: rtl/irc_pkg.sv
package irc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CAP_ARM,
    S_CAP_HEAD,
    S_CAP_DATA,
    S_CAP_MARK,
    S_TX_RUN,
    S_TX_FETCH,
    S_TX_LOAD
  } irc_state_e;

  typedef enum logic {
    MODE_LEARN  = 1'b0,
    MODE_REPLAY = 1'b1
  } irc_mode_e;

endpackage

// File: rtl/irc_strobe_gen.sv
module irc_strobe_gen #(
  parameter int unsigned CLK_PER_US = 5,
  parameter int unsigned HALF_CYC   = 66
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic burst_en_i,
  output logic tick_o,
  output logic carrier_o
);

  localparam int unsigned DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int unsigned PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] div_q;
  logic [PW-1:0] ph_q;
  logic          car_q;

  assign tick_o    = (div_q == DW'(CLK_PER_US - 1));
  assign carrier_o = car_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i || tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // phase restarts while dark so each burst opens high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      car_q <= 1'b1;
    end else if (!burst_en_i) begin
      ph_q  <= '0;
      car_q <= 1'b1;
    end else if (ph_q == PW'(HALF_CYC - 1)) begin
      ph_q  <= '0;
      car_q <= ~car_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  generate
    if (CLK_PER_US > 1) begin : g_tick_chk
      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R2
    end
  endgenerate

  AST_BURST_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_en_i) |-> carrier_o); // R9

endmodule

// File: rtl/irc_meter.sv
module irc_meter #(
  parameter int unsigned MAX_US = 4000,
  parameter int unsigned CW     = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          edge_o,
  output logic [CW-1:0] len_o,
  output logic          over_o
);

  localparam logic [CW-1:0] MAXC = CW'(MAX_US);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] hi_cnt_q, lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b1;
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      edge_o   <= 1'b0;
      over_o   <= 1'b0;
      len_o    <= '0;
    end else begin
      edge_o <= 1'b0;
      over_o <= 1'b0;
      if (clr_i) begin
        lvl_q    <= 1'b1;
        hi_cnt_q <= '0;
        lo_cnt_q <= '0;
      end else if (tick_i) begin
        if (s2_q != lvl_q) begin
          edge_o <= 1'b1;
          len_o  <= lvl_q ? hi_cnt_q : lo_cnt_q;
          lvl_q  <= s2_q;
          if (s2_q) begin
            hi_cnt_q <= CW'(1);
            lo_cnt_q <= '0;
          end else begin
            lo_cnt_q <= CW'(1);
            hi_cnt_q <= '0;
          end
        end else if (lvl_q) begin
          // saturate one past the limit so over fires once
          if (hi_cnt_q <= MAXC) hi_cnt_q <= hi_cnt_q + 1'b1;
          over_o <= (hi_cnt_q == MAXC);
        end else begin
          if (lo_cnt_q <= MAXC) lo_cnt_q <= lo_cnt_q + 1'b1;
          over_o <= (lo_cnt_q == MAXC);
        end
      end
    end
  end

  AST_OVER_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |=> !over_o); // R3

endmodule

// File: rtl/irc_code_ram.sv
module irc_code_ram #(
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 96
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/irc_capture_replay.sv
module irc_capture_replay
  import irc_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 5_000_000,
  parameter int unsigned CARRIER_HZ = 38_000,
  parameter int unsigned START_US   = 2400,
  parameter int unsigned MAX_US     = 4000,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned CODE_W     = 2,
  parameter int unsigned NUM_CODES  = 3,
  parameter int unsigned SLOT_AW    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_rx_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_sel_i,
  input  logic              start_i,
  output logic              ack_o,
  output logic              done_o,
  output logic              led_o
);

  localparam int unsigned CLK_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned HALF_CYC   = (CLK_HZ + CARRIER_HZ) / (2 * CARRIER_HZ);
  localparam int unsigned SLOT_N     = 1 << SLOT_AW;
  localparam int unsigned AW         = CODE_W + SLOT_AW;
  localparam int unsigned DEPTH      = NUM_CODES * SLOT_N;
  localparam int unsigned CW         = $clog2(MAX_US + 2);
  localparam int unsigned NW         = SLOT_AW + 1;
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_CODES - 1);

  irc_state_e          state_q;
  logic [CODE_W-1:0]   code_q;
  logic [SLOT_AW-1:0]  addr_q;
  logic [NW-1:0]       count_q;
  logic [DATA_W-1:0]   dcnt_q;
  logic                gate_q;

  logic                tick, carrier, accept;
  logic                m_edge, m_over;
  logic [CW-1:0]       m_len;
  logic                we;
  logic [AW-1:0]       mem_addr;
  logic [DATA_W-1:0]   wdata, rdata;

  assign accept   = (state_q == S_IDLE) && start_i && (code_sel_i <= LAST_CODE);
  assign mem_addr = {code_q, addr_q};
  assign we       = ((state_q == S_CAP_DATA) && m_edge) || (state_q == S_CAP_MARK);
  assign wdata    = (state_q == S_CAP_MARK) ? '0 : DATA_W'(m_len);
  assign led_o    = gate_q & carrier;

  irc_strobe_gen #(
    .CLK_PER_US(CLK_PER_US),
    .HALF_CYC  (HALF_CYC)
  ) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .burst_en_i(gate_q),
    .tick_o    (tick),
    .carrier_o (carrier)
  );

  irc_meter #(
    .MAX_US(MAX_US),
    .CW    (CW)
  ) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .tick_i(tick),
    .rx_i  (ir_rx_i),
    .edge_o(m_edge),
    .len_o (m_len),
    .over_o(m_over)
  );

  irc_code_ram #(
    .AW   (AW),
    .DW   (DATA_W),
    .DEPTH(DEPTH)
  ) u_ram (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(mem_addr),
    .wdata_i(wdata),
    .raddr_i(mem_addr),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      code_q  <= '0;
      addr_q  <= '0;
      count_q <= '0;
      dcnt_q  <= '0;
      gate_q  <= 1'b0;
      ack_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      ack_o  <= 1'b0;
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            code_q  <= code_sel_i;
            addr_q  <= '0;
            count_q <= '0;
            if (mode_i == MODE_REPLAY) begin
              gate_q  <= 1'b1;
              dcnt_q  <= DATA_W'(START_US);
              state_q <= S_TX_RUN;
            end else begin
              state_q <= S_CAP_ARM;
            end
          end
        end
        S_CAP_ARM: begin
          if (m_edge) state_q <= S_CAP_HEAD;
        end
        S_CAP_HEAD: begin
          // lead-in is timed but never written
          if (m_over)      state_q <= S_CAP_MARK;
          else if (m_edge) state_q <= S_CAP_DATA;
        end
        S_CAP_DATA: begin
          if (m_edge) begin
            addr_q  <= addr_q + 1'b1;
            count_q <= count_q + 1'b1;
            if (count_q == NW'(SLOT_N - 1)) begin
              ack_o   <= 1'b1;
              state_q <= S_IDLE;
            end
          end else if (m_over) begin
            state_q <= S_CAP_MARK;
          end
        end
        S_CAP_MARK: begin
          ack_o   <= 1'b1;
          state_q <= S_IDLE;
        end
        S_TX_RUN: begin
          if (tick) begin
            if (dcnt_q == DATA_W'(1)) state_q <= S_TX_FETCH;
            else                      dcnt_q  <= dcnt_q - 1'b1;
          end
        end
        S_TX_FETCH: state_q <= S_TX_LOAD;
        S_TX_LOAD: begin
          if (count_q == NW'(SLOT_N) || rdata == '0) begin
            gate_q  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            dcnt_q  <= rdata;
            gate_q  <= count_q[0];
            addr_q  <= addr_q + 1'b1;
            count_q <= count_q + 1'b1;
            state_q <= S_TX_RUN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_WRITE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && state_q == S_CAP_DATA) |-> (wdata != '0 && wdata <= DATA_W'(MAX_US))); // R3
  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (mem_addr[AW-1 -: CODE_W] <= LAST_CODE)); // R5
  AST_FILL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= NW'(SLOT_N)); // R4
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R3
  AST_DONE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !led_o); // R8
  AST_DCNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TX_RUN) |-> (dcnt_q != '0)); // R7

endmodule

// File: tb/irc_capture_replay_test.sv
module irc_capture_replay_test;

  localparam int CLK_PERIOD_NS = 200;
  localparam int CLK_HZ        = 5_000_000;
  localparam int CARRIER_HZ    = 2_500_000;
  localparam int START_US      = 40;
  localparam int MAX_US        = 300;
  localparam int CPU           = CLK_HZ / 1_000_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       mode = 1'b0;
  logic [1:0] code_sel = 2'd0;
  logic       start = 1'b0;
  logic       ack, done, led;

  irc_capture_replay #(
    .CLK_HZ    (CLK_HZ),
    .CARRIER_HZ(CARRIER_HZ),
    .START_US  (START_US),
    .MAX_US    (MAX_US)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ir_rx_i   (rx),
    .mode_i    (mode),
    .code_sel_i(code_sel),
    .start_i   (start),
    .ack_o     (ack),
    .done_o    (done),
    .led_o     (led)
  );

  initial forever #(CLK_PERIOD_NS / 2) clk = ~clk;

  int n_checks = 0, n_errors = 0;
  bit finished = 1'b0;

  // led monitor: bursts and preceding gaps in us
  int cyc = 0, ack_cnt = 0, done_cnt = 0, duty_viol = 0;
  int nb = 0, first_hi = 0, last_hi = 0;
  bit in_burst = 1'b0, prev_led = 1'b0;
  int bursts[1024];
  int gaps[1024];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      ack_cnt  += int'(ack);
      done_cnt += int'(done);
      if (led) begin
        if (prev_led) duty_viol++;
        if (!in_burst) begin
          gaps[nb] = (cyc - last_hi - 1 + 2) / CPU;
          in_burst = 1'b1;
          first_hi = cyc;
        end
        last_hi = cyc;
      end else if (in_burst && (cyc - last_hi) > 2) begin
        bursts[nb] = (last_hi - first_hi + 1 + 2) / CPU;
        nb++;
        in_burst = 1'b0;
      end
      prev_led = led;
    end
  end

  int seq[40];
  int model[3][32];
  int model_n[3];
  int ack_mid;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(bit m, int code);
    mode = m;
    code_sel = 2'(code);
    start = 1'b1;
    wait_clk(1);
    start = 1'b0;
  endtask

  task automatic level(bit v, int us);
    rx = v;
    wait_clk(us * CPU);
  endtask

  function automatic int stored_len(int n);
    for (int i = 0; i < n; i++) begin
      if (seq[i] > MAX_US) return (i < 32) ? i : 32;
      if (i == 32) return 32;
    end
    return (n < 32) ? n : 32;
  endfunction

  task automatic learn(int code, int n, int start_us);
    int a0 = ack_cnt;
    pulse_start(1'b0, code);
    wait_clk(3);
    level(1'b0, start_us);
    for (int i = 0; i < n; i++) begin
      if (i == 33) ack_mid = ack_cnt - a0;
      level((i % 2 == 0) ? 1'b1 : 1'b0, seq[i]);
    end
    level((n % 2 == 0) ? 1'b1 : 1'b0, MAX_US + 3);
    rx = 1'b1;
    wait_clk(20);
    if (code < 3) begin
      model_n[code] = stored_len(n);
      for (int i = 0; i < model_n[code]; i++) model[code][i] = seq[i];
      check(ack_cnt - a0 == 1, "R3", ack_cnt - a0, 1);
    end else begin
      check(ack_cnt - a0 == 0, "R6", ack_cnt - a0, 0);
    end
  endtask

  task automatic replay(int code, string tag, bit poke);
    int b = nb;
    int d0 = done_cnt;
    int a0 = ack_cnt;
    int n = model_n[code];
    int nexp = 1 + n / 2;
    pulse_start(1'b1, code);
    if (poke) begin
      wait_clk(20);
      pulse_start(1'b0, 1);
      wait_clk(30);
      pulse_start(1'b1, 0);
    end
    for (int t = 0; t < 60000 && done_cnt == d0; t++) wait_clk(1);
    wait_clk(10);
    check(done_cnt - d0 == 1, "R8", done_cnt - d0, 1);
    check(nb - b == nexp, "R8", nb - b, nexp);
    check(led == 1'b0, "R8", int'(led), 0);
    check(bursts[b] == START_US, "R11", bursts[b], START_US);
    if (nb - b == nexp) begin
      for (int k = 1; k < nexp; k++) begin
        check(bursts[b + k] == model[code][2 * k - 1], tag, bursts[b + k], model[code][2 * k - 1]);
        check(gaps[b + k] == model[code][2 * k - 2], tag, gaps[b + k], model[code][2 * k - 2]);
      end
    end
    if (poke) check(ack_cnt - a0 == 0, "R10", ack_cnt - a0, 0);
  endtask

  task automatic rand_seq(int n);
    for (int i = 0; i < n; i++) seq[i] = int'($urandom_range(60, 1));
  endtask

  initial begin
    void'($urandom(32'd1999));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(3);
    check(led == 1'b0 && done == 1'b0 && ack == 1'b0, "R1",
          {29'd0, led, done, ack}, 0);

    // code index 3 is refused in both modes
    begin
      int b = nb;
      int d0 = done_cnt;
      seq[0] = 8; seq[1] = 9;
      learn(3, 2, 20);
      pulse_start(1'b1, 3);
      wait_clk(400);
      check(done_cnt == d0, "R6", done_cnt - d0, 0);
      check(nb == b && !in_burst, "R6", nb - b, 0);
    end

    // random codes into each slot, then replay all three
    for (int c = 0; c < 3; c++) begin
      int n = int'($urandom_range(18, 1));
      rand_seq(n);
      learn(c, n, int'($urandom_range(90, 5)));
    end
    for (int c = 0; c < 3; c++) replay(c, "R2", 1'b0);
    for (int r = 0; r < 2; r++) begin
      int n = int'($urandom_range(20, 2));
      rand_seq(n);
      learn(2, n, 10 + 30 * r);
      replay(2, "R7", 1'b0);
    end

    // limit: exactly MAX kept; MAX+1 ends the code early
    seq[0] = MAX_US; seq[1] = 6; seq[2] = 9; seq[3] = MAX_US;
    learn(1, 4, 25);
    replay(1, "R3", 1'b0);
    seq[0] = 12; seq[1] = 7; seq[2] = MAX_US + 1; seq[3] = 8; seq[4] = 9;
    learn(1, 5, 25);
    check(model_n[1] == 2, "R3", model_n[1], 2);
    replay(1, "R3", 1'b0);
    // code ending on a high entry, timed out while low
    seq[0] = 15; seq[1] = 4; seq[2] = 22;
    learn(2, 3, 30);
    replay(2, "R7", 1'b0);

    // fill slot 0 completely; slot 2 must survive
    rand_seq(35);
    for (int i = 0; i < 35; i++) if (seq[i] < 5) seq[i] = 5;
    learn(0, 35, 30);
    check(ack_mid == 1, "R4", ack_mid, 1);
    check(model_n[0] == 32, "R4", model_n[0], 32);
    replay(0, "R4", 1'b0);
    replay(2, "R5", 1'b0);
    replay(1, "R5", 1'b0);

    // starts while busy are ignored
    replay(2, "R10", 1'b1);
    replay(0, "R10", 1'b0);

    check(duty_viol == 0, "R9", duty_viol, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule